// File: doc/BRIEF.md
# Differential Clock Output Gating Controller

This block sits behind a clock distribution buffer and decides, for each differential output pair, whether the pair carries the reference clock, is parked in a driven stop level, or floats. It takes the reference clock, board pins and control bits from a register file. The pins are a per-output enable, an active-low stop request, an active-low power-down request and a global polarity-invert strap. Each pair gets a true output, a complement output and an output-enable for the pad driver. The clock source may be the reference clock itself or a divide-by-two copy of it. The PLL and fan-out choice upstream is not modelled here; the reference clock input is whatever that path delivers.

Stop and power-down requests are synchronized to the reference clock. A pair enters or leaves its stop state only on a falling reference edge at which its source is low, so no shortened pulse reaches the pad. Output-enable gating is applied combinationally and overrides the stop logic. The number of pairs, the synchronizer depth, the enable pin mapping and the presence of the divider are parameters.

Top module: `diffclk_gate`

## Requirements
- R1: With `inv_pin`=0 the enable, stop and power-down pins are used as received; with `inv_pin`=1 all of them are logically inverted before use.
- R2: An active power-down request stops every pair, whatever the per-pair stop-control bits hold.
- R3: An active stop request stops pair i only when `cfg_stop_en[i]`=1; with the bit at 0 the pair keeps toggling.
- R4: A stopped pair whose float bit for the active cause is 0 drives `out_p`=1, `out_n`=0, `out_oe`=1.
- R5: A stopped pair floats (`out_oe`=0, `out_p`=`out_n`=0) when power-down is active with `cfg_pd_float`=1, or when its stop is active with `cfg_stop_float`=1. A pair with `out_oe`=0 always drives 0 on both outputs.
- R6: Pair i is disabled (`out_oe`=0, outputs 0) in the same cycle that `cfg_out_en[i]`=0 or its mapped enable pin is low after R1, and this overrides the stop state.
- R7: With the default mapping `oe_pin_i[0]` gates pair 0 and `oe_pin_i[1]` gates pair 3; neither pin affects pairs 1 and 2.
- R8: A running, enabled pair drives `out_oe`=1 with `out_n` the exact inverse of `out_p`, and the complement rule also holds in the driven stop state.
- R9: With `cfg_mode_normal`=1 `out_p` follows the reference clock; with 0 it follows a divider that toggles on every rising edge. A change of the mode bit takes effect at the next rising edge.
- R10: A pin-level change made during the low phase before rising edge k reaches the pair state at the falling edge after rising edge k+1 (normal mode), both on entry and on exit.
- R11: During and after reset every pair runs with all outputs enabled, and the divider starts at 0, so its first rising edge after reset release drives it to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock, also the source of the outputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| inv_pin | input | 1 | Polarity-invert strap for all control pins |
| oe_pin_i | input | N_OE_PIN | Output-enable pins, active high before inversion |
| stop_pin_n | input | 1 | Stop request, active low before inversion |
| pd_pin_n | input | 1 | Power-down request, active low before inversion |
| cfg_mode_normal | input | 1 | 1 = reference frequency, 0 = divide by two |
| cfg_stop_float | input | 1 | 1 = float pairs stopped by the stop pin |
| cfg_pd_float | input | 1 | 1 = float pairs stopped by power-down |
| cfg_out_en | input | N_OUT | Per-pair register enable |
| cfg_stop_en | input | N_OUT | Per-pair obedience to the stop pin |
| out_p | output | N_OUT | True clock outputs |
| out_n | output | N_OUT | Complement clock outputs |
| out_oe | output | N_OUT | Pad driver enables |

## Verification
The gating is tried with a stop request applied to a mix of obeying and free-running pairs, which separates the per-pair control bit from the global request. Power-down is applied with all stop-control bits cleared, which shows it ignores those bits, and each cause is then toggled between driven and floating. Enable pins are driven in opposite patterns, first plainly and then under inversion, which tells the pin mapping, the polarity strap and the register enable apart. The stop pin is moved one low phase before a rising edge and the pair is sampled in both phases around the two synchronizer edges, which catches a missing or extra stage. The divider is switched in while it holds 1, so a mode change that acted early would show.

// File: rtl/diffclk_gate_pkg.sv
`timescale 1ns/1ps
package diffclk_gate_pkg;

   typedef enum logic [1:0] {
      PAIR_RUN   = 2'd0,
      PAIR_HOLD  = 2'd1,
      PAIR_FLOAT = 2'd2
   } pair_mode_e;

   // Index of the enable pin serving output idx: number of mapped outputs below it.
   function automatic int pin_slot(input logic [31:0] mask, input int idx);
      int n;
      n = 0;
      for (int k = 0; k < 32; k++)
         if (k < idx && mask[k]) n++;
      return n;
   endfunction

endpackage

// File: rtl/diffclk_pin_cond.sv
`timescale 1ns/1ps
module diffclk_pin_cond
   import diffclk_gate_pkg::*;
#(
   parameter int                 N_OUT       = 4,
   parameter int                 N_OE_PIN    = 2,
   parameter logic [N_OUT-1:0]   OE_PIN_MASK = 4'b1001
) (
   input  logic                inv_pin,
   input  logic [N_OE_PIN-1:0] oe_pin_i,
   input  logic                stop_pin_n,
   input  logic                pd_pin_n,
   output logic [N_OUT-1:0]    pin_en,
   output logic                stop_act,
   output logic                pd_act
);
   logic [N_OE_PIN-1:0] oe_use;

   assign oe_use   = oe_pin_i ^ {N_OE_PIN{inv_pin}};
   assign stop_act = ~(stop_pin_n ^ inv_pin);
   assign pd_act   = ~(pd_pin_n ^ inv_pin);

   for (genvar i = 0; i < N_OUT; i++) begin : g_map
      if (OE_PIN_MASK[i]) begin : g_pin
         localparam int SLOT = pin_slot(32'(OE_PIN_MASK), i);
         assign pin_en[i] = oe_use[SLOT];
      end else begin : g_nopin
         assign pin_en[i] = 1'b1;
      end
   end
endmodule

// File: rtl/diffclk_sync.sv
`timescale 1ns/1ps
module diffclk_sync #(
   parameter int W      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= '0;
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/diffclk_src.sv
`timescale 1ns/1ps
module diffclk_src #(
   parameter bit HAS_DIV = 1'b1
) (
   input  logic clk_ref,
   input  logic rst_n,
   input  logic cfg_mode_normal,
   output logic src,
   output logic fall_ok
);
   if (HAS_DIV) begin : g_div
      logic mode_q;
      logic div_q;

      always_ff @(posedge clk_ref or negedge rst_n) begin
         if (!rst_n) begin
            mode_q <= 1'b1;
            div_q  <= 1'b0;
         end else begin
            mode_q <= cfg_mode_normal;
            div_q  <= ~div_q;
         end
      end

      assign src     = mode_q ? clk_ref : div_q;
      assign fall_ok = mode_q | ~div_q;
   end else begin : g_nodiv
      assign src     = clk_ref;
      assign fall_ok = 1'b1;
   end
endmodule

// File: rtl/diffclk_pair.sv
`timescale 1ns/1ps
module diffclk_pair
   import diffclk_gate_pkg::*;
(
   input  logic clk_ref,
   input  logic rst_n,
   input  logic src,
   input  logic fall_ok,
   input  logic stop_req,
   input  logic float_req,
   input  logic enable,
   output logic out_p,
   output logic out_n,
   output logic out_oe
);
   pair_mode_e state;

   // State moves only on a falling edge at which the source is low.
   always_ff @(negedge clk_ref or negedge rst_n) begin
      if (!rst_n)       state <= PAIR_RUN;
      else if (fall_ok) state <= !stop_req ? PAIR_RUN
                               : (float_req ? PAIR_FLOAT : PAIR_HOLD);
   end

   always_comb begin
      out_p  = 1'b0;
      out_n  = 1'b0;
      out_oe = 1'b0;
      if (enable) begin
         case (state)
            PAIR_RUN: begin
               out_p  = src;
               out_n  = ~src;
               out_oe = 1'b1;
            end
            PAIR_HOLD: begin
               out_p  = 1'b1;
               out_n  = 1'b0;
               out_oe = 1'b1;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/diffclk_gate.sv
`timescale 1ns/1ps
module diffclk_gate #(
   parameter int               N_OUT       = 4,
   parameter int               N_OE_PIN    = 2,
   parameter logic [N_OUT-1:0] OE_PIN_MASK = 4'b1001,
   parameter int               SYNC_STAGES = 2,
   parameter bit               HAS_DIV     = 1'b1
) (
   input  logic                clk_ref,
   input  logic                rst_n,
   input  logic                inv_pin,
   input  logic [N_OE_PIN-1:0] oe_pin_i,
   input  logic                stop_pin_n,
   input  logic                pd_pin_n,
   input  logic                cfg_mode_normal,
   input  logic                cfg_stop_float,
   input  logic                cfg_pd_float,
   input  logic [N_OUT-1:0]    cfg_out_en,
   input  logic [N_OUT-1:0]    cfg_stop_en,
   output logic [N_OUT-1:0]    out_p,
   output logic [N_OUT-1:0]    out_n,
   output logic [N_OUT-1:0]    out_oe
);
   localparam int N_REQ = 2;

   if (N_OUT < 1 || N_OUT > 32) begin : g_bad_nout
      $error("diffclk_gate: N_OUT out of range");
   end
   if (N_OE_PIN < 1 || N_OE_PIN != $countones(OE_PIN_MASK)) begin : g_bad_pins
      $error("diffclk_gate: N_OE_PIN must equal the number of mapped outputs");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("diffclk_gate: SYNC_STAGES must be at least 2");
   end

   logic [N_OUT-1:0] pin_en;
   logic             stop_act, pd_act;
   logic [N_REQ-1:0] req_s;
   logic             stop_s, pd_s;
   logic             src, fall_ok;

   diffclk_pin_cond #(
      .N_OUT(N_OUT), .N_OE_PIN(N_OE_PIN), .OE_PIN_MASK(OE_PIN_MASK)
   ) u_pins (
      .inv_pin(inv_pin), .oe_pin_i(oe_pin_i), .stop_pin_n(stop_pin_n),
      .pd_pin_n(pd_pin_n), .pin_en(pin_en), .stop_act(stop_act), .pd_act(pd_act)
   );

   diffclk_sync #(.W(N_REQ), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk_ref), .rst_n(rst_n), .d({pd_act, stop_act}), .q(req_s)
   );
   assign stop_s = req_s[0];
   assign pd_s   = req_s[1];

   diffclk_src #(.HAS_DIV(HAS_DIV)) u_src (
      .clk_ref(clk_ref), .rst_n(rst_n), .cfg_mode_normal(cfg_mode_normal),
      .src(src), .fall_ok(fall_ok)
   );

   for (genvar i = 0; i < N_OUT; i++) begin : g_pair
      logic own_stop;
      assign own_stop = stop_s & cfg_stop_en[i];

      diffclk_pair u_pair (
         .clk_ref(clk_ref), .rst_n(rst_n), .src(src), .fall_ok(fall_ok),
         .stop_req(pd_s | own_stop),
         .float_req((pd_s & cfg_pd_float) | (own_stop & cfg_stop_float)),
         .enable(cfg_out_en[i] & pin_en[i]),
         .out_p(out_p[i]), .out_n(out_n[i]), .out_oe(out_oe[i])
      );
   end
endmodule

// File: rtl/diffclk_gate_chk.sv
`timescale 1ns/1ps
module diffclk_gate_chk #(
   parameter int N_OUT = 4
) (
   input logic             clk_ref,
   input logic             rst_n,
   input logic             inv_pin,
   input logic             pd_pin_n,
   input logic             cfg_mode_normal,
   input logic [N_OUT-1:0] cfg_out_en,
   input logic [N_OUT-1:0] out_p,
   input logic [N_OUT-1:0] out_n,
   input logic [N_OUT-1:0] out_oe
);
   logic [2:0] since_rst;
   logic       pd_req;

   assign pd_req = ~(pd_pin_n ^ inv_pin);

   always_ff @(posedge clk_ref or negedge rst_n) begin
      if (!rst_n)              since_rst <= '0;
      else if (since_rst != 4) since_rst <= since_rst + 3'd1;
   end

   // R8: a driven pair always carries complementary levels
   a_r8_complement: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (out_oe & ~(out_p ^ out_n)) == '0);

   // R5: a floating pair drives nothing
   a_r5_float_quiet: assert property (@(posedge clk_ref) disable iff (!rst_n)
      ((~out_oe) & (out_p | out_n)) == '0);

   // R6: register disable removes the pad enable
   a_r6_reg_disable: assert property (@(posedge clk_ref) disable iff (!rst_n)
      ((~cfg_out_en) & out_oe) == '0);

   // R2: a power-down held across the synchronizer stops every pair
   a_r2_pd_stops_all: assert property (@(posedge clk_ref) disable iff (!rst_n)
      (since_rst == 4 && pd_req && $past(pd_req) && $past(pd_req, 2)
       && $past(pd_req, 3) && $past(cfg_mode_normal, 2))
      |-> ((~((~out_oe) | (out_p & ~out_n))) == '0));
endmodule

bind diffclk_gate diffclk_gate_chk #(.N_OUT(N_OUT)) u_chk (
   .clk_ref(clk_ref), .rst_n(rst_n), .inv_pin(inv_pin), .pd_pin_n(pd_pin_n),
   .cfg_mode_normal(cfg_mode_normal), .cfg_out_en(cfg_out_en),
   .out_p(out_p), .out_n(out_n), .out_oe(out_oe)
);

// File: tb/diffclk_gate_tb.sv
`timescale 1ns/1ps
module diffclk_gate_tb;
   localparam int N = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         inv_pin = 1'b0;
   logic [1:0]   oe_pin_i = 2'b11;
   logic         stop_pin_n = 1'b1, pd_pin_n = 1'b1;
   logic         cfg_mode_normal = 1'b1, cfg_stop_float = 1'b0, cfg_pd_float = 1'b0;
   logic [N-1:0] cfg_out_en = '1, cfg_stop_en = '0;
   logic [N-1:0] out_p, out_n, out_oe;

   int errors = 0, checks = 0;
   bit done = 0;
   int pe_cnt = 0;

   typedef struct {
      logic [N-1:0] p, n, oe;
      string        req;
   } exp_t;
   exp_t q[$];
   event smp_ev;

   always #2.5 clk = ~clk;

   always @(posedge clk) pe_cnt <= rst_n ? pe_cnt + 1 : 0;

   diffclk_gate u_dut (
      .clk_ref(clk), .rst_n(rst_n), .inv_pin(inv_pin), .oe_pin_i(oe_pin_i),
      .stop_pin_n(stop_pin_n), .pd_pin_n(pd_pin_n), .cfg_mode_normal(cfg_mode_normal),
      .cfg_stop_float(cfg_stop_float), .cfg_pd_float(cfg_pd_float),
      .cfg_out_en(cfg_out_en), .cfg_stop_en(cfg_stop_en),
      .out_p(out_p), .out_n(out_n), .out_oe(out_oe)
   );

   // Monitor: pops expected items and compares against the pins.
   initial forever begin
      @(smp_ev);
      while (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (out_p !== e.p || out_n !== e.n || out_oe !== e.oe) begin
            errors++;
            $display("FAIL %s: p=%b n=%b oe=%b expected p=%b n=%b oe=%b",
                     e.req, out_p, out_n, out_oe, e.p, e.n, e.oe);
         end
      end
   end

   task automatic expect_now(input logic [N-1:0] p, n, oe, input string req);
      exp_t e;
      e.p = p; e.n = n; e.oe = oe; e.req = req;
      q.push_back(e);
      -> smp_ev;
      #0.1;
   endtask

   task automatic at_high();
      @(posedge clk); #1.25;
   endtask
   task automatic at_low();
      @(negedge clk); #1.25;
   endtask
   task automatic settle(input int n);
      repeat (n) @(posedge clk);
      at_low();
   endtask

   initial begin
      // R11: running while held in reset
      at_high(); expect_now(4'b1111, 4'b0000, 4'b1111, "R11 reset high phase");
      at_low();  expect_now(4'b0000, 4'b1111, 4'b1111, "R11 reset low phase");
      rst_n = 1'b1;
      at_low();  expect_now(4'b0000, 4'b1111, 4'b1111, "R8 running low");
      at_high(); expect_now(4'b1111, 4'b0000, 4'b1111, "R8 running high");

      // R3: stop pin ignored by pairs whose stop bit is 0
      stop_pin_n = 1'b0;
      settle(4); expect_now(4'b0000, 4'b1111, 4'b1111, "R3 stop ignored");
      cfg_stop_en = 4'b0101;
      at_low(); expect_now(4'b0101, 4'b1010, 4'b1111, "R3 R4 selective driven stop");
      cfg_stop_float = 1'b1;
      at_low(); expect_now(4'b0000, 4'b1010, 4'b1010, "R5 stop floats");

      // R10: exit timing
      stop_pin_n = 1'b1;
      at_low();  expect_now(4'b0000, 4'b1010, 4'b1010, "R10 exit after one edge");
      at_high(); expect_now(4'b1010, 4'b0000, 4'b1010, "R10 exit after two edges");
      at_low();  expect_now(4'b0000, 4'b1111, 4'b1111, "R10 exit at fall");

      // R10: entry timing
      cfg_stop_float = 1'b0; cfg_stop_en = 4'b1111; stop_pin_n = 1'b0;
      at_low();  expect_now(4'b0000, 4'b1111, 4'b1111, "R10 entry after one edge");
      at_high(); expect_now(4'b1111, 4'b0000, 4'b1111, "R10 entry after two edges");
      at_low();  expect_now(4'b1111, 4'b0000, 4'b1111, "R10 entry at fall");
      stop_pin_n = 1'b1; cfg_stop_en = '0;
      settle(4); expect_now(4'b0000, 4'b1111, 4'b1111, "R3 released");

      // R2: power-down overrides cleared stop bits
      pd_pin_n = 1'b0;
      settle(4); expect_now(4'b1111, 4'b0000, 4'b1111, "R2 R4 power-down driven");
      cfg_pd_float = 1'b1;
      settle(2); expect_now(4'b0000, 4'b0000, 4'b0000, "R5 power-down floats");
      cfg_pd_float = 1'b0; pd_pin_n = 1'b1;
      settle(4); expect_now(4'b0000, 4'b1111, 4'b1111, "R2 released");

      // R1: inversion strap
      inv_pin = 1'b1;
      at_high(); expect_now(4'b0110, 4'b0000, 4'b0110, "R1 R6 inverted enables");
      settle(4); expect_now(4'b0110, 4'b0000, 4'b0110, "R1 inverted power-down");
      oe_pin_i = 2'b00; pd_pin_n = 1'b0; stop_pin_n = 1'b0;
      settle(4); expect_now(4'b0000, 4'b1111, 4'b1111, "R1 inverted idle levels");
      inv_pin = 1'b0; oe_pin_i = 2'b11; pd_pin_n = 1'b1; stop_pin_n = 1'b1;
      settle(4); expect_now(4'b0000, 4'b1111, 4'b1111, "R1 plain idle levels");

      // R7: pin mapping
      oe_pin_i = 2'b01;
      at_high(); expect_now(4'b0111, 4'b0000, 4'b0111, "R7 pin1 gates pair3");
      oe_pin_i = 2'b10;
      at_low();  expect_now(4'b0000, 4'b1110, 4'b1110, "R7 pin0 gates pair0");
      oe_pin_i = 2'b11;

      // R6: register disable beats stop
      cfg_out_en = 4'b1110; cfg_stop_en = 4'b1111; stop_pin_n = 1'b0;
      settle(4); expect_now(4'b1110, 4'b0000, 4'b1110, "R6 enable priority");
      cfg_out_en = '1; cfg_stop_en = '0; stop_pin_n = 1'b1;
      settle(4);

      // R9: divide mode, switched while the divider holds 1
      at_high();
      while (pe_cnt[0] != 1'b1) at_high();
      cfg_mode_normal = 1'b0;
      at_low(); expect_now(4'b0000, 4'b1111, 4'b1111, "R9 mode waits for edge");
      for (int k = 0; k < 3; k++) begin
         at_high();
         expect_now({N{pe_cnt[0]}}, {N{~pe_cnt[0]}}, 4'b1111, "R9 R11 divider high phase");
         at_low();
         expect_now({N{pe_cnt[0]}}, {N{~pe_cnt[0]}}, 4'b1111, "R9 R11 divider low phase");
      end
      cfg_stop_en = 4'b1111; stop_pin_n = 1'b0;
      settle(6); expect_now(4'b1111, 4'b0000, 4'b1111, "R9 R4 stop in divide mode");
      stop_pin_n = 1'b1; cfg_stop_en = '0;
      settle(6); cfg_mode_normal = 1'b1;
      settle(2); expect_now(4'b0000, 4'b1111, 4'b1111, "R9 back to normal");

      at_low();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog: run incomplete, expected finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule